// File: doc/BRIEF.md
# Synchronous Burst SRAM Core

This block models a synchronous static RAM of 32-bit words split into four byte lanes. The address is registered and the read data is not: the addressed word reaches the output combinationally during the cycle after the address was captured. Two address strobes are provided. One is for a processor side and the other is for a cache controller side. Either strobe can load a new address on a rising clock edge, but only the controller strobe can start a write.

An advance input steps a 2-bit burst offset within an aligned group of four words. A mode input selects linear or interleaved order. Three chip-select inputs are sampled only on strobe edges, and the resulting selected or deselected state is held between those edges.

A snooze input drives a four-state sleep machine:

- `SLP_AWAKE` moves to `SLP_ENTER` when snooze is sampled high.
- `SLP_ENTER` moves to `SLP_ASLEEP` after the fourth consecutive high sample, or returns to `SLP_AWAKE` if snooze drops first.
- `SLP_ASLEEP` moves to `SLP_LEAVE` when snooze is sampled low.
- `SLP_LEAVE` moves to `SLP_AWAKE` after the fourth consecutive low sample, or returns to `SLP_ASLEEP` if snooze rises again.

The device is asleep in `SLP_ASLEEP` and `SLP_LEAVE`. While asleep it ignores every command and keeps the array contents. The output driver is modelled by a data bus together with an enable flag: a low enable stands for high impedance.

Top module: `burst_sram_core`

## Requirements
- R1: While reset is asserted, and after it is released until a selecting strobe edge occurs, `dout_en` is low.
- R2: A rising edge where `cpu_stb_n` or `ctl_stb_n` is low, the device is awake, and the sampled selects give "selected" loads `addr` and clears the burst offset. In the following cycle, with `oe_n` low and no write lane active, `dout_en` is high and `dout` shows that word in the same cycle.
- R3: `sel_a_n`, `sel_b` and `sel_c_n` are sampled only on strobe edges. The device is selected when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. A deselecting strobe edge holds `dout_en` low until a later selecting strobe edge, and changes on the selects at other edges have no effect.
- R4: An awake, selected edge with both strobes high and `adv_n` low adds one to the 2-bit offset. With `burst_mode`=0, the low two address bits are (base + offset) mod 4. The upper address bits never change without a strobe.
- R5: With `burst_mode`=1, the low two address bits are base XOR offset.
- R6: The write lane mask works as follows. If `all_wr_n`=0, all four lanes are written. Otherwise, if `lane_wr_en_n`=0, lane i (data bits 8i+7..8i) is written when `byte_we_n[i]`=0. Otherwise no lane is written.
- R7: A write takes place only when `cpu_stb_n` is sampled high. An edge with `cpu_stb_n` low is a read even if lanes are active.
- R8: A write on an edge that loads a new address goes to that new address. Any other write goes to the current burst address, and an advance on that edge takes effect after the write.
- R9: `dout_en` is high only when `oe_n` is low and the write lane mask is empty. An active lane disables the output even when `oe_n` is low.
- R10: After four consecutive edges with `snooze` high, the device is asleep. From then on `dout_en` is low and loads, advances, select sampling and writes are ignored.
- R11: After four consecutive edges with `snooze` low, the device wakes. The array, the address and the select state are as they were before sleep.
- R12: While deselected, no write reaches the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | AW | Word address, loaded on strobe edges |
| cpu_stb_n | input | 1 | Processor-side address strobe, active low, never writes |
| ctl_stb_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| byte_we_n | input | 4 | Per-lane write enables, active low |
| lane_wr_en_n | input | 1 | Qualifies the per-lane enables, active low |
| all_wr_n | input | 1 | Writes all lanes, active low |
| oe_n | input | 1 | Output enable, active low |
| burst_mode | input | 1 | 1 = interleaved order, 0 = linear order |
| snooze | input | 1 | Sleep request |
| din | input | 32 | Write data |
| dout | output | 32 | Read data, zero when not driven |
| dout_en | output | 1 | High when the read data is driven, low for high impedance |

## Verification
The assertions assume that every input is at a known level at each rising edge and that `addr` stays inside the configured depth. The bench meets this by driving all inputs only just after falling edges, from a fixed-seed generator, with addresses confined to a 32-word window that was filled at the start. Snooze changes rarely and at random, so both completed and aborted sleep entries and exits occur. The assertions on the sleep edges rely on `snooze` being sampled at the same edges as the commands.

// File: rtl/bsram_pkg.sv
package bsram_pkg;

    typedef enum logic [1:0] {
        SLP_AWAKE,
        SLP_ENTER,
        SLP_ASLEEP,
        SLP_LEAVE
    } slp_state_e;

    // Low address bits for a given burst step.
    function automatic logic [1:0] burst_offset(input logic [1:0] base,
                                                input logic [1:0] step,
                                                input logic       interleave);
        return interleave ? (base ^ step) : (base + step);
    endfunction

    // Lanes a cycle would write, before strobe and select qualification.
    function automatic logic [3:0] lane_mask(input logic       all_n,
                                             input logic       lanes_en_n,
                                             input logic [3:0] per_lane_n);
        logic [3:0] m;
        if (!all_n)           m = 4'hF;
        else if (!lanes_en_n) m = ~per_lane_n;
        else                  m = 4'h0;
        return m;
    endfunction

endpackage

// File: rtl/bsram_sleep_fsm.sv
module bsram_sleep_fsm
    import bsram_pkg::*;
#(
    parameter int SLEEP_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic snooze,
    output logic asleep
);
    localparam int CW = $clog2(SLEEP_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(SLEEP_CYC - 1);

    slp_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            SLP_AWAKE: begin
                if (snooze) begin
                    state_d = SLP_ENTER;
                    cnt_d   = CW'(1);
                end
            end
            SLP_ENTER: begin
                if (!snooze) begin
                    state_d = SLP_AWAKE;
                    cnt_d   = '0;
                end else if (cnt_q == LAST) begin
                    state_d = SLP_ASLEEP;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + CW'(1);
                end
            end
            SLP_ASLEEP: begin
                if (!snooze) begin
                    state_d = SLP_LEAVE;
                    cnt_d   = CW'(1);
                end
            end
            SLP_LEAVE: begin
                if (snooze) begin
                    state_d = SLP_ASLEEP;
                    cnt_d   = '0;
                end else if (cnt_q == LAST) begin
                    state_d = SLP_AWAKE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + CW'(1);
                end
            end
            default: begin
                state_d = SLP_AWAKE;
                cnt_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SLP_AWAKE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        asleep = (state_q == SLP_ASLEEP) || (state_q == SLP_LEAVE);
    end

endmodule

// File: rtl/bsram_addr_ctl.sv
module bsram_addr_ctl
    import bsram_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          awake,
    input  logic [AW-1:0] addr,
    input  logic          cpu_stb_n,
    input  logic          ctl_stb_n,
    input  logic          adv_n,
    input  logic          sel_a_n,
    input  logic          sel_b,
    input  logic          sel_c_n,
    input  logic          interleave,
    output logic          sel_now,
    output logic          sel_q,
    output logic [AW-1:0] cur_addr,
    output logic [AW-1:0] wr_addr
);
    logic          strobe;
    logic          load;
    logic          step;
    logic [AW-1:0] base_q;
    logic [1:0]    cnt_q;

    always_comb begin
        strobe  = !cpu_stb_n || !ctl_stb_n;
        sel_now = strobe ? (!sel_a_n && sel_b && !sel_c_n) : sel_q;
        load    = awake && strobe && sel_now;
        step    = awake && sel_q && !strobe && !adv_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q  <= 1'b0;
            base_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (awake && strobe) sel_q <= sel_now;
            if (load) begin
                base_q <= addr;
                cnt_q  <= 2'd0;
            end else if (step) begin
                cnt_q <= cnt_q + 2'd1;
            end
        end
    end

    always_comb begin
        cur_addr = {base_q[AW-1:2], burst_offset(base_q[1:0], cnt_q, interleave)};
        wr_addr  = load ? addr : cur_addr;
    end

endmodule

// File: rtl/bsram_array.sv
module bsram_array #(
    parameter int DEPTH = 1024,
    parameter int AW    = 10
) (
    input  logic          clk,
    input  logic [3:0]    we_mask,
    input  logic [AW-1:0] waddr,
    input  logic [31:0]   wdata,
    input  logic [AW-1:0] raddr,
    output logic [31:0]   rdata
);
    for (genvar g = 0; g < 4; g++) begin : g_lane
        logic [7:0] lane_mem [DEPTH];

        always_ff @(posedge clk) begin
            if (we_mask[g]) lane_mem[waddr] <= wdata[g*8 +: 8];
        end

        assign rdata[g*8 +: 8] = lane_mem[raddr];
    end

endmodule

// File: rtl/burst_sram_core.sv
module burst_sram_core
    import bsram_pkg::*;
#(
    parameter int DEPTH     = 1024,
    parameter int SLEEP_CYC = 4,
    localparam int AW       = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          cpu_stb_n,
    input  logic          ctl_stb_n,
    input  logic          adv_n,
    input  logic          sel_a_n,
    input  logic          sel_b,
    input  logic          sel_c_n,
    input  logic [3:0]    byte_we_n,
    input  logic          lane_wr_en_n,
    input  logic          all_wr_n,
    input  logic          oe_n,
    input  logic          burst_mode,
    input  logic          snooze,
    input  logic [31:0]   din,
    output logic [31:0]   dout,
    output logic          dout_en
);
    logic          asleep;
    logic          sel_now;
    logic          sel_q;
    logic [AW-1:0] cur_addr;
    logic [AW-1:0] wr_addr;
    logic [3:0]    lanes;
    logic [3:0]    we_mask;
    logic [31:0]   rdata;

    bsram_sleep_fsm #(.SLEEP_CYC(SLEEP_CYC)) u_sleep (
        .clk    (clk),
        .rst_n  (rst_n),
        .snooze (snooze),
        .asleep (asleep)
    );

    bsram_addr_ctl #(.AW(AW)) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .awake      (!asleep),
        .addr       (addr),
        .cpu_stb_n  (cpu_stb_n),
        .ctl_stb_n  (ctl_stb_n),
        .adv_n      (adv_n),
        .sel_a_n    (sel_a_n),
        .sel_b      (sel_b),
        .sel_c_n    (sel_c_n),
        .interleave (burst_mode),
        .sel_now    (sel_now),
        .sel_q      (sel_q),
        .cur_addr   (cur_addr),
        .wr_addr    (wr_addr)
    );

    always_comb begin
        lanes   = lane_mask(all_wr_n, lane_wr_en_n, byte_we_n);
        we_mask = (!asleep && sel_now && cpu_stb_n) ? lanes : 4'h0;
    end

    bsram_array #(.DEPTH(DEPTH), .AW(AW)) u_array (
        .clk     (clk),
        .we_mask (we_mask),
        .waddr   (wr_addr),
        .wdata   (din),
        .raddr   (cur_addr),
        .rdata   (rdata)
    );

    always_comb begin
        dout_en = sel_q && !asleep && !oe_n && (lanes == 4'h0);
        dout    = dout_en ? rdata : 32'h0;
    end

endmodule

// File: rtl/bsram_core_chk.sv
module bsram_core_chk #(
    parameter int AW = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          oe_n,
    input logic          all_wr_n,
    input logic          lane_wr_en_n,
    input logic [3:0]    byte_we_n,
    input logic          cpu_stb_n,
    input logic          ctl_stb_n,
    input logic          snooze,
    input logic          dout_en,
    input logic          selected,
    input logic          asleep,
    input logic [AW-1:0] cur_addr
);
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> !dout_en);

    p_deselect_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !selected |-> !dout_en);

    p_upper_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_stb_n && ctl_stb_n) |=> $stable(cur_addr[AW-1:2]));

    p_oe_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dout_en |-> (!oe_n && all_wr_n && (lane_wr_en_n || (&byte_we_n))));

    p_sleep_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        asleep |-> !dout_en);

    p_sleep_entry_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(asleep) |-> $past(snooze));

    p_sleep_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        asleep |=> $stable(cur_addr[AW-1:2]));

    p_wake_exit_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(asleep) |-> !$past(snooze));

endmodule

bind burst_sram_core bsram_core_chk #(.AW(AW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .oe_n         (oe_n),
    .all_wr_n     (all_wr_n),
    .lane_wr_en_n (lane_wr_en_n),
    .byte_we_n    (byte_we_n),
    .cpu_stb_n    (cpu_stb_n),
    .ctl_stb_n    (ctl_stb_n),
    .snooze       (snooze),
    .dout_en      (dout_en),
    .selected     (sel_q),
    .asleep       (asleep),
    .cur_addr     (cur_addr)
);

// File: tb/burst_sram_core_bench.sv
module burst_sram_core_bench;
    localparam int DEPTH = 1024;
    localparam int AW    = 10;
    localparam int SLP   = 4;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n;
    logic [AW-1:0] addr;
    logic          cpu_stb_n, ctl_stb_n, adv_n;
    logic          sel_a_n, sel_b, sel_c_n;
    logic [3:0]    byte_we_n;
    logic          lane_wr_en_n, all_wr_n, oe_n, burst_mode, snooze;
    logic [31:0]   din, dout;
    logic          dout_en;

    burst_sram_core #(.DEPTH(DEPTH), .SLEEP_CYC(SLP)) u_burst_sram_core (
        .clk(clk), .rst_n(rst_n), .addr(addr), .cpu_stb_n(cpu_stb_n),
        .ctl_stb_n(ctl_stb_n), .adv_n(adv_n), .sel_a_n(sel_a_n), .sel_b(sel_b),
        .sel_c_n(sel_c_n), .byte_we_n(byte_we_n), .lane_wr_en_n(lane_wr_en_n),
        .all_wr_n(all_wr_n), .oe_n(oe_n), .burst_mode(burst_mode), .snooze(snooze),
        .din(din), .dout(dout), .dout_en(dout_en)
    );

    int n_chk  = 0;
    int n_fail = 0;

    // reference state built from the requirements
    logic [31:0]   ref_mem [DEPTH];
    logic [3:0]    ref_vld [DEPTH];
    bit            m_sel, m_asleep;
    int            m_streak;
    logic [AW-1:0] m_base;
    logic [1:0]    m_cnt;

    function automatic logic [31:0] pat(input int a);
        return (a * 32'h0101_0101) ^ 32'hC35A_96E1;
    endfunction

    function automatic logic [3:0] exp_lanes();
        if (!all_wr_n)     return 4'hF;
        if (!lane_wr_en_n) return ~byte_we_n;
        return 4'h0;
    endfunction

    function automatic logic [AW-1:0] m_cur();
        logic [1:0] lo;
        lo = burst_mode ? (m_base[1:0] ^ m_cnt) : (m_base[1:0] + m_cnt);
        return {m_base[AW-1:2], lo};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        logic exp_en;
        exp_en = m_sel && !m_asleep && !oe_n && (exp_lanes() == 4'h0);
        chk(dout_en === exp_en, tag, {31'h0, dout_en}, {31'h0, exp_en});
        if (exp_en && ref_vld[m_cur()] == 4'hF)
            chk(dout === ref_mem[m_cur()], tag, dout, ref_mem[m_cur()]);
    endtask

    task automatic model_edge();
        bit            awake, strobe, sel_now, load;
        logic [AW-1:0] wa;
        logic [3:0]    ln;
        awake   = !m_asleep;
        strobe  = !cpu_stb_n || !ctl_stb_n;
        sel_now = strobe ? (!sel_a_n && sel_b && !sel_c_n) : m_sel;
        load    = awake && strobe && sel_now;
        wa      = load ? addr : m_cur();
        ln      = exp_lanes();
        if (awake && sel_now && cpu_stb_n) begin
            for (int i = 0; i < 4; i++) begin
                if (ln[i]) begin
                    ref_mem[wa][i*8 +: 8] = din[i*8 +: 8];
                    ref_vld[wa][i]        = 1'b1;
                end
            end
        end
        if (load) begin
            m_base = addr;
            m_cnt  = 2'd0;
        end else if (awake && m_sel && !strobe && !adv_n) begin
            m_cnt = m_cnt + 2'd1;
        end
        if (awake && strobe) m_sel = sel_now;
        if (snooze != m_asleep) m_streak++;
        else                    m_streak = 0;
        if (m_streak == SLP) begin
            m_asleep = !m_asleep;
            m_streak = 0;
        end
    endtask

    task automatic tick(input string tag);
        #1;
        compare(tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    task automatic idle();
        cpu_stb_n = 1'b1; ctl_stb_n = 1'b1; adv_n = 1'b1;
        all_wr_n = 1'b1; lane_wr_en_n = 1'b1; byte_we_n = 4'hF; oe_n = 1'b0;
    endtask

    task automatic rd_expect(input logic [31:0] val, input string tag);
        #1;
        chk(dout_en === 1'b1 && dout === val, tag, dout, val);
        tick(tag);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog (R1..): actual timeout expected completion");
        summary();
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < DEPTH; i++) ref_vld[i] = 4'h0;
        m_sel = 0; m_asleep = 0; m_streak = 0; m_base = '0; m_cnt = '0;
        rst_n = 1'b0; addr = '0; din = '0; burst_mode = 1'b0; snooze = 1'b0;
        sel_a_n = 1'b0; sel_b = 1'b1; sel_c_n = 1'b0;
        idle();
        repeat (3) @(negedge clk);
        #1 chk(dout_en === 1'b0, "R1 in reset", {31'h0, dout_en}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        tick("R1 after release");

        // fill words 0..31 through the controller strobe (R8: write to loaded address)
        for (int a = 0; a < 32; a++) begin
            idle(); ctl_stb_n = 1'b0; addr = AW'(a); all_wr_n = 1'b0; din = pat(a);
            tick("R8");
        end

        // R2: processor load, flow-through data next cycle
        idle(); cpu_stb_n = 1'b0; addr = 10'd5; tick("R2");
        idle(); rd_expect(pat(5), "R2");

        // R4: linear burst from 14 -> 14,15,12,13 then hold
        idle(); burst_mode = 1'b0; cpu_stb_n = 1'b0; addr = 10'd14; tick("R4");
        idle(); adv_n = 1'b0;
        rd_expect(pat(14), "R4"); rd_expect(pat(15), "R4");
        rd_expect(pat(12), "R4"); rd_expect(pat(13), "R4");
        idle(); rd_expect(pat(14), "R4 wrap");

        // R5: interleaved burst from 13 -> 13,12,15,14
        idle(); burst_mode = 1'b1; cpu_stb_n = 1'b0; addr = 10'd13; tick("R5");
        idle(); adv_n = 1'b0;
        rd_expect(pat(13), "R5"); rd_expect(pat(12), "R5");
        rd_expect(pat(15), "R5"); rd_expect(pat(14), "R5");
        burst_mode = 1'b0;

        // R7: processor strobe with lanes active is a read; R9: output off meanwhile
        idle(); cpu_stb_n = 1'b0; addr = 10'd3; all_wr_n = 1'b0; din = 32'hDEAD_BEEF;
        #1 chk(dout_en === 1'b0, "R9 lanes active", {31'h0, dout_en}, 32'h0);
        tick("R7");
        idle(); rd_expect(pat(3), "R7");
        idle(); oe_n = 1'b1; tick("R9 oe high");

        // R6: lane subset, global override, unqualified lanes
        idle(); ctl_stb_n = 1'b0; addr = 10'd20; lane_wr_en_n = 1'b0;
        byte_we_n = 4'b1010; din = 32'h1122_3344; tick("R6");
        idle(); rd_expect({pat(20)[31:24], 8'h22, pat(20)[15:8], 8'h44}, "R6 subset");
        idle(); ctl_stb_n = 1'b0; addr = 10'd21; all_wr_n = 1'b0; lane_wr_en_n = 1'b0;
        byte_we_n = 4'hF; din = 32'h5566_7788; tick("R6");
        idle(); rd_expect(32'h5566_7788, "R6 global");
        idle(); ctl_stb_n = 1'b0; addr = 10'd22; lane_wr_en_n = 1'b1;
        byte_we_n = 4'h0; din = 32'h0BAD_0BAD; tick("R6");
        idle(); rd_expect(pat(22), "R6 unqualified");

        // R8: write during advance goes to current address, then steps
        idle(); cpu_stb_n = 1'b0; addr = 10'd16; tick("R8");
        idle(); all_wr_n = 1'b0; adv_n = 1'b0; din = 32'hA1B2_C3D4; tick("R8");
        idle(); rd_expect(pat(17), "R8 advanced");
        idle(); cpu_stb_n = 1'b0; addr = 10'd16; tick("R8");
        idle(); rd_expect(32'hA1B2_C3D4, "R8 written");

        // R3 / R12: deselect, ignored writes, select changes off-strobe
        idle(); cpu_stb_n = 1'b0; addr = 10'd0; sel_b = 1'b0; tick("R3");
        idle(); sel_b = 1'b1;
        #1 chk(dout_en === 1'b0, "R3 held deselect", {31'h0, dout_en}, 32'h0);
        tick("R3");
        idle(); all_wr_n = 1'b0; din = 32'hFFFF_0000; tick("R12");
        idle(); ctl_stb_n = 1'b0; sel_a_n = 1'b1; addr = 10'd0; all_wr_n = 1'b0;
        din = 32'h0F0F_0F0F; tick("R12");
        sel_a_n = 1'b0;
        idle(); cpu_stb_n = 1'b0; addr = 10'd0; tick("R3");
        idle(); rd_expect(pat(0), "R12");

        // R10 / R11: sleep entry, ignored commands, wake with state kept
        idle(); cpu_stb_n = 1'b0; addr = 10'd1; tick("R10");
        idle(); snooze = 1'b1;
        for (int k = 0; k < SLP; k++) tick("R10");
        #1 chk(dout_en === 1'b0, "R10 asleep", {31'h0, dout_en}, 32'h0);
        idle(); ctl_stb_n = 1'b0; addr = 10'd4; all_wr_n = 1'b0; din = 32'h7777_7777;
        tick("R10");
        idle(); snooze = 1'b0;
        for (int k = 0; k < SLP; k++) tick("R11");
        idle(); rd_expect(pat(1), "R11 address kept");
        idle(); cpu_stb_n = 1'b0; addr = 10'd4; tick("R11");
        idle(); rd_expect(pat(4), "R11 contents kept");

        // constrained random phase
        for (int n = 0; n < 3000; n++) begin
            addr         = AW'($urandom % 32);
            cpu_stb_n    = ($urandom % 100) >= 20;
            ctl_stb_n    = ($urandom % 100) >= 20;
            adv_n        = ($urandom % 100) >= 40;
            sel_a_n      = ($urandom % 100) < 5;
            sel_b        = ($urandom % 100) >= 5;
            sel_c_n      = ($urandom % 100) < 5;
            oe_n         = ($urandom % 100) < 20;
            all_wr_n     = ($urandom % 100) >= 10;
            lane_wr_en_n = ($urandom % 100) >= 30;
            byte_we_n    = 4'($urandom);
            din          = $urandom;
            if (($urandom % 50) == 0) burst_mode = ~burst_mode;
            if (($urandom % 100) < 3) snooze = ~snooze;
            tick("R2 random");
        end
        summary();
    end

endmodule